// File: doc/BRIEF.md
# Synchronous USB FIFO Command Reader

This block sits between an external synchronous-FIFO USB bridge and the command logic of a chip. It runs in the bridge's 60 MHz clock domain. The bridge drives an active-low "receive data available" line when it has bytes for the chip.

When that line goes low, the block starts a fixed read handshake. First it enables the bridge's output drivers with an active-low output enable. One clock later it asserts the active-low read strobe. It then takes one byte per clock from the 8-bit bus.

Four bytes make one command, in this order:
1. opcode
2. address
3. high byte of the value
4. low byte of the value

The finished command leaves the block as a single 32-bit word with a one-clock valid strobe. The bus is bidirectional at the pads, so the block brings out a separate input, output and driver enable for it. The driver enable stays off, because this block only reads. Moving the command into another clock domain is left to the logic that consumes it.

Top module: `fifo_rd_engine`

## Requirements
- R1: During reset and after it, while `rxf_n` is high, `rd_n` and `oe_n` are high, `cmd_valid` is low and `cmd_word` is zero.
- R2: The handshake starts only on a clock edge at which the block is idle and `rxf_n` is low. While `rxf_n` stays high, `rd_n` and `oe_n` never go low.
- R3: `oe_n` goes low after the first edge that sees `rxf_n` low. `rd_n` goes low one edge later, while `oe_n` is still low. `rd_n` is never low while `oe_n` is high.
- R4: Once `rd_n` is low, the block samples `bus_in` on each of the next four edges. Counting edges from the start edge as E0, the bytes are taken at E2 to E5, in the order opcode, address, value high, value low.
- R5: After E5, `cmd_valid` is high for exactly one clock. In that clock, `cmd_word` holds opcode in bits 31:24, address in 23:16, value high in 15:8 and value low in 7:0.
- R6: If `rxf_n` is seen high at an edge while `oe_n` is low and the command is not complete, the block returns to idle. `rd_n` and `oe_n` go high, no `cmd_valid` is produced, and the next command is built only from its own four bytes.
- R7: `bus_drive_en` stays low at all times, so the block never drives the shared bus.
- R8: In the clock where `cmd_valid` is high, `rd_n` and `oe_n` are both high. If `rxf_n` is still low, the next handshake begins at the following edge, and back-to-back commands each give exactly one valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxf_n | input | 1 | Active-low receive data available from bridge |
| bus_in | input | 8 | Data bus input path |
| bus_out | output | 8 | Data bus output path (unused, zero) |
| bus_drive_en | output | 1 | Data bus driver enable, held low |
| rd_n | output | 1 | Active-low read strobe to bridge |
| oe_n | output | 1 | Active-low bridge output enable |
| cmd_valid | output | 1 | One-clock strobe for a finished command |
| cmd_word | output | 32 | Packed command: opcode, address, value high, value low |

## Verification
The hardest case to reach from the ports is a receive-available line that drops part-way through a command. There are separate windows for this: during output-enable setup, and before each of the four byte samples. In each window, stale bytes must not leak into the next command.

The stimulus covers these windows by sweeping the abort point over every step of the handshake. After each abort it sends a full command with a fresh word, so any leftover byte would show up in the packed output. Back-to-back runs hold the line low across command boundaries, which reaches the re-arm path straight from the valid cycle.

// File: rtl/fifo_rd_engine.sv
module fifo_rd_engine #(
  parameter int BYTE_W    = 8,
  parameter int CMD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rxf_n,
  input  logic [BYTE_W-1:0]             bus_in,
  output logic [BYTE_W-1:0]             bus_out,
  output logic                          bus_drive_en,
  output logic                          rd_n,
  output logic                          oe_n,
  output logic                          cmd_valid,
  output logic [CMD_BYTES*BYTE_W-1:0]   cmd_word
);

  localparam int WORD_W = CMD_BYTES * BYTE_W;
  localparam int CNT_W  = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_OE_SETUP, S_READ} rd_state_t;

  rd_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;

  assign next_word    = {shreg[WORD_W-BYTE_W-1:0], bus_in};
  assign rd_n         = (state != S_READ);
  assign oe_n         = (state == S_IDLE);
  assign bus_out      = '0;
  assign bus_drive_en = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!rxf_n) state <= S_OE_SETUP;
        end
        S_OE_SETUP: state <= rxf_n ? S_IDLE : S_READ;
        S_READ: begin
          if (rxf_n) begin
            state <= S_IDLE;
          end else begin
            shreg <= next_word;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              state     <= S_IDLE;
              cmd_valid <= 1'b1;
              cmd_word  <= next_word;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fifo_rd_engine_chk.sv
module fifo_rd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rxf_n,
  input logic rd_n,
  input logic oe_n,
  input logic cmd_valid
);

  assert_start_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(rxf_n) == 1'b0);

  assert_oe_leads_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(oe_n) == 1'b0);

  assert_rd_inside_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe_n);

  assert_setup_then_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && rd_n) |=> (!rd_n || oe_n));

  assert_valid_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(rd_n) == 1'b0);

  assert_single_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && rxf_n) |=> (rd_n && oe_n && !cmd_valid));

  assert_released_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (rd_n && oe_n));

endmodule

bind fifo_rd_engine fifo_rd_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n),
  .rd_n(rd_n), .oe_n(oe_n), .cmd_valid(cmd_valid)
);

// File: tb/test_fifo_rd_engine.sv
`timescale 1ns / 1ps
module test_fifo_rd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxf_n = 1'b1;
  logic [7:0]  bus_in = 8'h00;
  logic [7:0]  bus_out;
  logic        bus_drive_en;
  logic        rd_n, oe_n, cmd_valid;
  logic [31:0] cmd_word;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  bit drv_seen = 1'b0;

  always #5 clk = ~clk;

  fifo_rd_engine i_fifo_rd_engine (
    .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_drive_en(bus_drive_en), .rd_n(rd_n), .oe_n(oe_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && cmd_valid) pulses <= pulses + 1;
    if (bus_drive_en) drv_seen <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mkword(input int i);
    return {8'(i * 29 + 3), 8'(i * 113), 8'(~i), 8'(i ^ 8'h5A)};
  endfunction

  // Full command from an idle negedge; keep_low leaves rxf_n asserted for the next one.
  task automatic run_cmd(input logic [31:0] w, input bit keep_low);
    rxf_n = 1'b0;
    bus_in = w[31:24];
    check(rd_n && oe_n, "R2", {30'd0, rd_n, oe_n}, 32'h3);
    step();
    check(!oe_n && rd_n, "R3", {30'd0, rd_n, oe_n}, 32'h2);
    step();
    check(!oe_n && !rd_n, "R3", {30'd0, rd_n, oe_n}, 32'h0);
    step();
    bus_in = w[23:16];
    step();
    bus_in = w[15:8];
    step();
    bus_in = w[7:0];
    check(!cmd_valid, "R4", {31'd0, cmd_valid}, 32'h0);
    step();
    check(cmd_valid === 1'b1, "R5", {31'd0, cmd_valid}, 32'h1);
    check(cmd_word === w, "R4", cmd_word, w);
    check(rd_n && oe_n, "R8", {30'd0, rd_n, oe_n}, 32'h3);
    if (!keep_low) begin
      rxf_n = 1'b1;
      step();
      check(!cmd_valid, "R5", {31'd0, cmd_valid}, 32'h0);
    end
  endtask

  // Abort: rxf_n rises at the negedge after edge E<s> (s = 0 .. 4).
  task automatic run_abort(input logic [31:0] w, input int s);
    int base;
    base = pulses;
    rxf_n = 1'b0;
    bus_in = w[31:24];
    for (int k = 0; k <= s; k++) step();
    rxf_n = 1'b1;
    bus_in = 8'hEE;
    step();
    check(rd_n && oe_n, "R6", {30'd0, rd_n, oe_n}, 32'h3);
    step();
    step();
    check(pulses == base, "R6", pulses, base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_n && oe_n && !cmd_valid && cmd_word == 32'h0, "R1", {29'd0, rd_n, oe_n, cmd_valid}, 32'h6);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      bus_in = 8'(k * 41);
      step();
      check(rd_n && oe_n && !cmd_valid, "R2", {29'd0, rd_n, oe_n, cmd_valid}, 32'h6);
    end
    check(cmd_word == 32'h0, "R1", cmd_word, 32'h0);

    for (int i = 0; i < 64; i++) begin
      run_cmd(mkword(i), 1'b0);
      step();
    end
    run_cmd(32'h0000_0000, 1'b0);
    run_cmd(32'hFFFF_FFFF, 1'b0);

    for (int s = 0; s <= 4; s++) begin
      run_abort(32'hA5A5_A5A5 ^ 32'(s), s);
      run_cmd(mkword(100 + s), 1'b0);
    end

    begin
      int base;
      base = pulses;
      for (int i = 0; i < 8; i++) run_cmd(mkword(200 + i), 1'b1);
      rxf_n = 1'b1;
      step();
      step();
      check(pulses == base + 8, "R8", pulses, base + 8);
    end

    check(!drv_seen && !bus_drive_en && bus_out == 8'h00, "R7", {23'd0, drv_seen, bus_out}, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule